// File: doc/BRIEF.md
# Register-Offset Vector Load Address Stage

This block is one pipeline stage in front of a load unit that fills a vector or floating-point register. Each accepted cycle it takes a 32-bit instruction word, the two integer register values already read for it (base and index), the current stack-pointer value and a floating-point enable. It decodes the word, extends and scales the index, adds the base and registers the result.

A word enters on a valid/ready handshake: it is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output slot is empty or is being drained in the same cycle (`!out_valid || out_ready`). A result stays on the output, unchanged, until a cycle where `out_ready` is high. Words that do not have this load's fixed bits are taken and dropped. They leave no result and raise no undefined flag.

A result carries the destination register, the access size in bytes and the 64-bit effective address. It also carries two exception flags: an undefined-instruction flag and a stack-alignment flag. The undefined flag wins over the alignment flag.

Top module: `ldg_addr_gen`

## Requirements
- R1: A word is recognised only when bits 29:27 are 111, bit 26 is 1, bits 25:24 are 00, bit 22 is 1, bit 21 is 1 and bits 11:10 are 10. An accepted word that fails this gives `out_valid` 0 on the next cycle.
- R2: A recognised word whose index-mode field (bits 15:13) has bit 14 equal to 0 is reported with `out_undef` 1.
- R3: A recognised word with bit 23 equal to 1 and the size field (bits 31:30) not 00 is reported with `out_undef` 1.
- R4: When `fp_en` is 0 at acceptance, a recognised word is reported with `out_undef` 1.
- R5: For a defined word, `out_bytes` is 16 when bit 23 is 1, and otherwise 1, 2, 4 or 8 for size 00, 01, 10 or 11.
- R6: Index mode 010 zero-extends index bits 31:0. Mode 110 sign-extends index bits 31:0. Modes 011 and 111 use all 64 index bits.
- R7: When bit 12 is 1, the extended index is shifted left by log2 of the access size in bytes. When bit 12 is 0, it is not shifted.
- R8: The base is `sp_val` when bits 9:5 equal 31 and `base_val` otherwise. `out_addr` is base plus the shifted index, modulo 2^64. `out_rt` is bits 4:0.
- R9: `out_align` is 1 exactly when bits 9:5 equal 31, the low 4 bits of `sp_val` are nonzero and `out_undef` is 0.
- R10: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and every output holds its value.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word and operands are present |
| in_ready | output | 1 | Stage can take a word this cycle |
| in_word | input | 32 | Instruction word |
| fp_en | input | 1 | Floating point enabled |
| base_val | input | 64 | Value of the base register named by bits 9:5 |
| index_val | input | 64 | Value of the index register named by bits 20:16 |
| sp_val | input | 64 | Current stack-pointer value |
| out_valid | output | 1 | A result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_undef | output | 1 | Undefined-instruction flag |
| out_align | output | 1 | Stack-pointer alignment fault |
| out_rt | output | 5 | Destination vector register index |
| out_bytes | output | 5 | Access size in bytes |
| out_addr | output | 64 | Effective address |

## Verification
Every result is due exactly one rising edge after the edge that accepts its word. `in_ready` follows the output state within the same cycle. The bench drives inputs just after a falling edge and samples the outputs at the next falling edge after the accepting edge. In the stall case it waits extra edges with `out_ready` low and checks that the earlier result is still there. It then checks that the held-back word appears one edge after `out_ready` rises.

// File: rtl/ldg_pkg.sv
package ldg_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned RIDX_W  = 5;
  localparam int unsigned SCALE_W = 3;
  localparam int unsigned BYTES_W = 5;
  localparam logic [RIDX_W-1:0] SP_IDX = '1;

  typedef enum logic [1:0] {
    EXT_ZERO32 = 2'd0,
    EXT_SIGN32 = 2'd1,
    EXT_FULL   = 2'd2
  } ext_kind_e;

  typedef struct packed {
    logic               match;
    logic               undef;
    logic [RIDX_W-1:0]  rt;
    logic               base_is_sp;
    logic [SCALE_W-1:0] scale;
    logic [SCALE_W-1:0] shift;
    ext_kind_e          ext;
  } dec_t;
endpackage

// File: rtl/ldg_field_decode.sv
module ldg_field_decode
  import ldg_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              fp_en,
  output dec_t              dec
);
  logic [1:0] sz;
  logic [1:0] opc;
  logic [2:0] mode;
  logic       fixed_ok;
  logic       rsvd_mode;
  logic       rsvd_size;

  always_comb begin
    sz   = word[31:30];
    opc  = word[23:22];
    mode = word[15:13];

    fixed_ok  = (word[29:27] == 3'b111) && word[26] && (word[25:24] == 2'b00)
              && word[21] && (word[11:10] == 2'b10) && opc[0];
    rsvd_mode = !mode[1];
    rsvd_size = opc[1] && (sz != 2'b00);

    dec.match      = fixed_ok;
    dec.undef      = !fp_en || rsvd_mode || rsvd_size;
    dec.rt         = word[4:0];
    dec.base_is_sp = (word[9:5] == SP_IDX);
    dec.scale      = opc[1] ? SCALE_W'(4) : SCALE_W'(sz);
    dec.shift      = word[12] ? dec.scale : '0;
    if (mode[0])      dec.ext = EXT_FULL;
    else if (mode[2]) dec.ext = EXT_SIGN32;
    else              dec.ext = EXT_ZERO32;
  end
endmodule

// File: rtl/ldg_index_extend.sv
module ldg_index_extend
  import ldg_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0]    idx,
  input  ext_kind_e          ext,
  input  logic [SCALE_W-1:0] shift,
  output logic [XLEN-1:0]    offset
);
  localparam int unsigned HALF = XLEN / 2;

  logic [XLEN-1:0] widened;

  always_comb begin
    unique case (ext)
      EXT_ZERO32: widened = {{(XLEN-HALF){1'b0}}, idx[HALF-1:0]};
      EXT_SIGN32: widened = {{(XLEN-HALF){idx[HALF-1]}}, idx[HALF-1:0]};
      default:    widened = idx;
    endcase
    offset = widened << shift;
  end
endmodule

// File: rtl/ldg_base_select.sv
module ldg_base_select #(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned ALIGN_BITS = 4
) (
  input  logic            use_sp,
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] sp_val,
  output logic [XLEN-1:0] base,
  output logic            sp_misaligned
);
  assign base = use_sp ? sp_val : base_val;

  generate
    if (ALIGN_BITS == 0) begin : g_no_align
      assign sp_misaligned = 1'b0;
    end else begin : g_align
      assign sp_misaligned = use_sp && (|sp_val[ALIGN_BITS-1:0]);
    end
  endgenerate
endmodule

// File: rtl/ldg_addr_gen.sv
module ldg_addr_gen
  import ldg_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned ALIGN_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   in_word,
  input  logic                fp_en,
  input  logic [XLEN-1:0]     base_val,
  input  logic [XLEN-1:0]     index_val,
  input  logic [XLEN-1:0]     sp_val,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_undef,
  output logic                out_align,
  output logic [RIDX_W-1:0]   out_rt,
  output logic [BYTES_W-1:0]  out_bytes,
  output logic [XLEN-1:0]     out_addr
);
  dec_t            dec;
  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] base;
  logic            sp_mis;
  logic            take;

  ldg_field_decode u_dec (
    .word  (in_word),
    .fp_en (fp_en),
    .dec   (dec)
  );

  ldg_index_extend #(.XLEN(XLEN)) u_ext (
    .idx    (index_val),
    .ext    (dec.ext),
    .shift  (dec.shift),
    .offset (offset)
  );

  ldg_base_select #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS)) u_base (
    .use_sp        (dec.base_is_sp),
    .base_val      (base_val),
    .sp_val        (sp_val),
    .base          (base),
    .sp_misaligned (sp_mis)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_undef <= 1'b0;
      out_align <= 1'b0;
      out_rt    <= '0;
      out_bytes <= '0;
      out_addr  <= '0;
    end else if (in_ready) begin
      out_valid <= take && dec.match;
      if (take && dec.match) begin
        out_undef <= dec.undef;
        out_align <= sp_mis && !dec.undef;
        out_rt    <= dec.rt;
        out_bytes <= BYTES_W'(1) << dec.scale;
        out_addr  <= base + offset;
      end
    end
  end
endmodule

// File: rtl/ldg_addr_gen_chk.sv
module ldg_addr_gen_chk
  import ldg_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [WORD_W-1:0]  in_word,
  input logic               fp_en,
  input logic               out_valid,
  input logic               out_ready,
  input logic               out_undef,
  input logic               out_align,
  input logic [RIDX_W-1:0]  out_rt,
  input logic [BYTES_W-1:0] out_bytes,
  input logic [XLEN-1:0]    out_addr
);
  logic fixed_bits;
  assign fixed_bits = (in_word[29:24] == 6'b111100) && in_word[22] && in_word[21]
                    && (in_word[11:10] == 2'b10);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_rt)
      && $stable(out_bytes) && $stable(out_undef) && $stable(out_align));

  p_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_undef |-> !out_align);

  p_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_undef |-> ($countones(out_bytes) == 1));

  p_fpoff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && fixed_bits && !fp_en |=> out_valid && out_undef);

  p_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !fixed_bits |=> !out_valid);
endmodule

bind ldg_addr_gen ldg_addr_gen_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_word   (in_word),
  .fp_en     (fp_en),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_undef (out_undef),
  .out_align (out_align),
  .out_rt    (out_rt),
  .out_bytes (out_bytes),
  .out_addr  (out_addr)
);

// File: tb/test_ldg_addr_gen.sv
module test_ldg_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        fp_en = 1'b1;
  logic [63:0] base_val = '0;
  logic [63:0] index_val = '0;
  logic [63:0] sp_val = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_undef;
  logic        out_align;
  logic [4:0]  out_rt;
  logic [4:0]  out_bytes;
  logic [63:0] out_addr;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldg_addr_gen i_ldg_addr_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .fp_en(fp_en), .base_val(base_val), .index_val(index_val),
    .sp_val(sp_val), .out_valid(out_valid), .out_ready(out_ready),
    .out_undef(out_undef), .out_align(out_align), .out_rt(out_rt),
    .out_bytes(out_bytes), .out_addr(out_addr)
  );

  function automatic logic [31:0] mk(input logic [1:0] sz, input logic [1:0] opc,
                                     input logic [4:0] rm, input logic [2:0] mode,
                                     input logic s, input logic [4:0] rn, input logic [4:0] rt);
    return {sz, 3'b111, 1'b1, 2'b00, opc, 1'b1, rm, mode, s, 2'b10, rn, rt};
  endfunction

  function automatic logic e_match(input logic [31:0] w);
    return (w[29:24] == 6'b111100) && w[22] && w[21] && (w[11:10] == 2'b10);
  endfunction

  function automatic logic e_undef(input logic [31:0] w, input logic fp);
    return !fp || !w[14] || (w[23] && (w[31:30] != 2'b00));
  endfunction

  function automatic int e_log2(input logic [31:0] w);
    return w[23] ? 4 : int'(w[31:30]);
  endfunction

  function automatic logic [63:0] e_addr(input logic [31:0] w, input logic [63:0] b,
                                         input logic [63:0] ix, input logic [63:0] sp);
    logic [63:0] v;
    logic [63:0] bb;
    case (w[15:13])
      3'b010:  v = {32'h0, ix[31:0]};
      3'b110:  v = {{32{ix[31]}}, ix[31:0]};
      default: v = ix;
    endcase
    if (w[12]) v = v << e_log2(w);
    bb = (w[9:5] == 5'd31) ? sp : b;
    return bb + v;
  endfunction

  function automatic logic e_align(input logic [31:0] w, input logic [63:0] sp, input logic fp);
    return (w[9:5] == 5'd31) && (sp[3:0] != 4'h0) && !e_undef(w, fp);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w, input logic [63:0] b, input logic [63:0] ix,
                      input logic [63:0] sp, input logic fp);
    @(negedge clk);
    in_word = w; base_val = b; index_val = ix; sp_val = sp; fp_en = fp;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic full_check(input string tag, input logic [31:0] w, input logic [63:0] b,
                            input logic [63:0] ix, input logic [63:0] sp, input logic fp);
    chk({tag, " valid"}, 64'(out_valid), 64'(e_match(w)));
    if (e_match(w)) begin
      chk({tag, " undef"}, 64'(out_undef), 64'(e_undef(w, fp)));
      chk({tag, " align"}, 64'(out_align), 64'(e_align(w, sp, fp)));
      if (!e_undef(w, fp)) begin
        chk({tag, " bytes"}, 64'(out_bytes), 64'(1) << e_log2(w));
        chk({tag, " rt"}, 64'(out_rt), 64'(w[4:0]));
        chk({tag, " addr"}, out_addr, e_addr(w, b, ix, sp));
      end
    end
  endtask

  task automatic run(input string tag, input logic [31:0] w, input logic [63:0] b,
                     input logic [63:0] ix, input logic [63:0] sp, input logic fp);
    send(w, b, ix, sp, fp);
    full_check(tag, w, b, ix, sp, fp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] wa;
    logic [31:0] wb;
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 reset out_valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset in_ready", 64'(in_ready), 64'd1);

    run("R5 R8 byte lsl", mk(2'b00, 2'b01, 5'd2, 3'b011, 1'b0, 5'd3, 5'd7),
        64'h1000, 64'h20, 64'h0, 1'b1);
    run("R6 R7 half uxtw", mk(2'b01, 2'b01, 5'd4, 3'b010, 1'b1, 5'd1, 5'd9),
        64'h8000, 64'hFFFF_FFFF_8000_0001, 64'h0, 1'b1);
    run("R6 R7 word sxtw", mk(2'b10, 2'b01, 5'd4, 3'b110, 1'b1, 5'd1, 5'd10),
        64'h1000, 64'h0000_0000_FFFF_FFFF, 64'h0, 1'b1);
    run("R6 R7 dword sxtx", mk(2'b11, 2'b01, 5'd4, 3'b111, 1'b1, 5'd2, 5'd11),
        64'h4000, 64'h0000_0001_0000_0010, 64'h0, 1'b1);
    run("R5 R7 quad", mk(2'b00, 2'b11, 5'd4, 3'b011, 1'b1, 5'd2, 5'd31),
        64'h100, 64'h3, 64'h0, 1'b1);
    run("R2 mode 000", mk(2'b10, 2'b01, 5'd4, 3'b000, 1'b0, 5'd2, 5'd1),
        64'h100, 64'h3, 64'h0, 1'b1);
    run("R3 quad bad size", mk(2'b01, 2'b11, 5'd4, 3'b011, 1'b0, 5'd2, 5'd1),
        64'h100, 64'h3, 64'h0, 1'b1);
    run("R4 fp off", mk(2'b10, 2'b01, 5'd4, 3'b011, 1'b0, 5'd2, 5'd1),
        64'h100, 64'h3, 64'h0, 1'b0);
    run("R8 R9 sp aligned", mk(2'b11, 2'b01, 5'd4, 3'b011, 1'b1, 5'd31, 5'd5),
        64'hDEAD, 64'h2, 64'h7000, 1'b1);
    run("R9 sp misaligned", mk(2'b11, 2'b01, 5'd4, 3'b011, 1'b0, 5'd31, 5'd5),
        64'hDEAD, 64'h2, 64'h7008, 1'b1);
    run("R9 undef wins", mk(2'b11, 2'b01, 5'd4, 3'b001, 1'b0, 5'd31, 5'd5),
        64'hDEAD, 64'h2, 64'h7008, 1'b1);
    chk("R9 undef wins align", 64'(out_align), 64'd0);
    run("R8 wrap", mk(2'b00, 2'b01, 5'd4, 3'b011, 1'b0, 5'd6, 5'd5),
        64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 64'h0, 1'b1);
    chk("R8 wrap addr", out_addr, 64'h1);
    run("R1 bad fixed bit", mk(2'b00, 2'b01, 5'd4, 3'b011, 1'b0, 5'd6, 5'd5) ^ 32'h0000_0400,
        64'h0, 64'h2, 64'h0, 1'b1);
    run("R1 opc low zero", mk(2'b10, 2'b00, 5'd4, 3'b011, 1'b0, 5'd6, 5'd5),
        64'h0, 64'h2, 64'h0, 1'b1);
    chk("R1 no undef output", 64'(out_valid), 64'd0);

    wa = mk(2'b10, 2'b01, 5'd1, 3'b011, 1'b0, 5'd2, 5'd12);
    wb = mk(2'b11, 2'b01, 5'd1, 3'b011, 1'b1, 5'd2, 5'd13);
    send(wa, 64'h5000, 64'h10, 64'h0, 1'b1);
    out_ready = 1'b0;
    in_word = wb; base_val = 64'h9000; index_val = 64'h1; in_valid = 1'b1;
    #1;
    chk("R10 in_ready low", 64'(in_ready), 64'd0);
    repeat (2) begin
      @(posedge clk);
      @(negedge clk);
    end
    chk("R10 hold valid", 64'(out_valid), 64'd1);
    chk("R10 hold addr", out_addr, 64'h5010);
    chk("R10 hold rt", 64'(out_rt), 64'd12);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 next addr", out_addr, 64'h9008);
    chk("R10 next rt", 64'(out_rt), 64'd13);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      logic [1:0]  opc;
      logic [63:0] b;
      logic [63:0] ix;
      logic [63:0] sp;
      logic        fp;
      opc = ($urandom % 2 == 0) ? 2'b01 : 2'b11;
      if ($urandom % 8 == 0) opc = 2'($urandom);
      w = mk(2'($urandom), opc, 5'($urandom), 3'($urandom), 1'($urandom),
             ($urandom % 4 == 0) ? 5'd31 : 5'($urandom), 5'($urandom));
      if ($urandom % 10 == 0) w = w ^ (32'h1 << ($urandom % 32));
      b  = {$urandom, $urandom};
      ix = {$urandom, $urandom};
      sp = {$urandom, $urandom};
      if ($urandom % 2 == 0) sp[3:0] = 4'h0;
      fp = ($urandom % 8 != 0);
      run("R1 R2 R3 R4 R5 R6 R7 R8 R9 random", w, b, ix, sp, fp);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule